// File: doc/BRIEF.md
# Register Transaction Request Builder and Response Checker

This block sits between a register-access client and a byte-oriented packet layer. The client hands it one command at a time. Each command carries a direction, a 32-bit register address and a word count. For writes, the client also supplies a stream of 32-bit data words. The block serializes an eight-byte request header, followed by any write payload, as a byte stream toward the packet layer. It then waits for the response bytes to come back. Framing, escaping and serial transport are handled elsewhere.

On the return path, the block behaves according to the direction of the request:

- For a read, the response is raw data with no header. The block packs it into 32-bit words and delivers them on a word stream.
- For a write, the response is a four-byte acknowledgement. The block compares it against the request.

Each command ends with a one-cycle completion pulse carrying a two-bit status:

- 0: success
- 1: rejected word count
- 2: malformed or mismatched response
- 3: response timeout

All data paths are valid/ready streams. A byte or word moves only in a cycle where both valid and ready are high. A source that has raised valid keeps it high, with its data unchanged, until the transfer happens. The outgoing byte stream may be stalled at any cycle. The write word stream is consumed one word per four outgoing payload bytes, and the word must stay stable while its four bytes are sent. The read word stream may also be stalled. While a word waits there, the incoming byte stream is held off.

Top module: `reg_txn_engine`

## Requirements
- R1: The request begins with eight header bytes in this order: transaction code; a reserved byte of 0x00; the 16-bit size, high byte first; the 32-bit address, most significant byte first.
- R2: The transaction code is chosen as follows:
  - single write (count 1): 0x00
  - sequential write (count > 1): 0x04
  - single read (count 1): 0x10
  - sequential read (count > 1): 0x14
- R3: The size field in the header equals the word count times four, for both reads and writes.
- R4: After the header, a write sends count × 4 payload bytes. Each word is sent least significant byte first. One word is taken from the write word stream per four bytes, and tx_last is high only on the final request byte.
- R5: A read request consists of the header alone, eight bytes, with tx_last on the eighth.
- R6: Read response bytes are packed least significant byte first into 32-bit words and delivered on the read word stream. Exactly the word count of words is delivered for a correctly sized response.
- R7: A read completes with status 2 when the number of response bytes up to and including the one marked rx_last differs from the word count times four. Otherwise it completes with status 0.
- R8: A write completes with status 0 only when its response meets all of these conditions:
  - exactly four bytes long;
  - first byte equal to the request code with bit 7 set;
  - last two bytes, taken high byte first, equal to the size sent.

  Any other write response gives status 2.
- R9: A command with a word count of zero, or above MAX_WORDS, sends no bytes and completes with status 1 in the cycle after it is accepted.
- R10: If no response byte marked rx_last arrives within TIMEOUT_CYC cycles after the last request byte, the command completes with status 3.
- R11: While tx_valid is high and tx_ready is low, tx_valid stays high and tx_data stays unchanged. The same holds for rd_valid and rd_data while rd_ready is low.
- R12: After reset, cmd_ready is 1 and both tx_valid and done are 0. Each accepted command produces exactly one done pulse, one cycle long. cmd_ready is high only between commands, when no read word is waiting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command accepted this cycle when both high |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_addr | input | 32 | Register address |
| cmd_count | input | CNT_W | Number of 32-bit words |
| wd_valid | input | 1 | Write data word offered |
| wd_ready | output | 1 | Write data word consumed |
| wd_data | input | 32 | Write data word |
| tx_valid | output | 1 | Request byte offered |
| tx_ready | input | 1 | Packet layer takes the byte |
| tx_data | output | 8 | Request byte |
| tx_last | output | 1 | Final byte of the request |
| rx_valid | input | 1 | Response byte offered |
| rx_ready | output | 1 | Response byte taken |
| rx_data | input | 8 | Response byte |
| rx_last | input | 1 | Final byte of the response packet |
| rd_valid | output | 1 | Read word offered |
| rd_ready | input | 1 | Client takes the read word |
| rd_data | output | 32 | Read word |
| done | output | 1 | One-cycle completion pulse |
| done_status | output | 2 | Completion status, valid with done |

## Verification
The hardest condition to reach from the ports is the response timeout. It needs a request that has finished leaving the block, followed by a return path that stays silent for the whole window. The bench runs with TIMEOUT_CYC lowered to 64, issues a read, and never answers. It then measures the cycles from the last request byte to the done pulse.

A second hard case is a write word caught mid-transfer by a stalled byte stream. The bench toggles tx_ready every cycle during a three-word sequential write. This exercises stalls on header bytes, on payload bytes and on word boundaries in a single run.

// File: rtl/reg_txn_pkg.sv
package reg_txn_pkg;

  typedef enum logic [1:0] {
    ST_OK      = 2'd0,
    ST_BADCNT  = 2'd1,
    ST_BADRESP = 2'd2,
    ST_TIMEOUT = 2'd3
  } txn_status_e;

  localparam logic [7:0] OP_WR     = 8'h00;
  localparam logic [7:0] OP_WR_SEQ = 8'h04;
  localparam logic [7:0] OP_RD     = 8'h10;
  localparam logic [7:0] OP_RD_SEQ = 8'h14;
  localparam logic [7:0] ACK_FLAG  = 8'h80;

  localparam int HDR_BYTES = 8;
  localparam int ACK_BYTES = 4;

  function automatic logic [7:0] op_code(input logic is_wr, input logic multi);
    if (is_wr) return multi ? OP_WR_SEQ : OP_WR;
    else       return multi ? OP_RD_SEQ : OP_RD;
  endfunction

endpackage

// File: rtl/reg_txn_tx.sv
module reg_txn_tx
  import reg_txn_pkg::*;
#(
  parameter int MAX_WORDS = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        is_wr,
  input  logic [7:0]  op,
  input  logic [31:0] addr,
  input  logic [15:0] size,
  output logic        tx_valid,
  input  logic        tx_ready,
  output logic [7:0]  tx_data,
  output logic        tx_last,
  input  logic        wd_valid,
  output logic        wd_ready,
  input  logic [31:0] wd_data,
  output logic        sent
);

  localparam int TOT_MAX = HDR_BYTES + 4 * MAX_WORDS;
  localparam int IDX_W   = $clog2(TOT_MAX + 1);

  logic             active;
  logic [IDX_W-1:0] idx;
  logic             wr_q;
  logic [7:0]       op_q;
  logic [31:0]      addr_q;
  logic [15:0]      size_q;

  logic [IDX_W-1:0] total;
  logic             in_hdr;
  logic [1:0]       bsel;
  logic [7:0]       hdr_b;
  logic             fire;

  assign total  = wr_q ? IDX_W'(HDR_BYTES) + IDX_W'(size_q) : IDX_W'(HDR_BYTES);
  assign in_hdr = (idx < IDX_W'(HDR_BYTES));
  assign bsel   = idx[1:0];

  always_comb begin
    case (idx[2:0])
      3'd0:    hdr_b = op_q;
      3'd1:    hdr_b = 8'h00;
      3'd2:    hdr_b = size_q[15:8];
      3'd3:    hdr_b = size_q[7:0];
      3'd4:    hdr_b = addr_q[31:24];
      3'd5:    hdr_b = addr_q[23:16];
      3'd6:    hdr_b = addr_q[15:8];
      default: hdr_b = addr_q[7:0];
    endcase
  end

  assign tx_valid = active && (in_hdr || wd_valid);
  assign tx_data  = in_hdr ? hdr_b : wd_data[8*bsel +: 8];
  assign tx_last  = active && (idx == total - IDX_W'(1));
  assign wd_ready = active && !in_hdr && tx_ready && (bsel == 2'd3);
  assign fire     = tx_valid && tx_ready;
  assign sent     = fire && tx_last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      idx    <= '0;
      wr_q   <= 1'b0;
      op_q   <= 8'h00;
      addr_q <= '0;
      size_q <= '0;
    end else if (start) begin
      active <= 1'b1;
      idx    <= '0;
      wr_q   <= is_wr;
      op_q   <= op;
      addr_q <= addr;
      size_q <= size;
    end else if (fire) begin
      if (tx_last) active <= 1'b0;
      else         idx    <= idx + IDX_W'(1);
    end
  end

  assert_tx_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));

endmodule

// File: rtl/reg_txn_rx.sv
module reg_txn_rx
  import reg_txn_pkg::*;
#(
  parameter int MAX_WORDS = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        abort,
  input  logic        is_wr,
  input  logic [7:0]  op,
  input  logic [15:0] size,
  input  logic        rx_valid,
  output logic        rx_ready,
  input  logic [7:0]  rx_data,
  input  logic        rx_last,
  output logic        rd_valid,
  input  logic        rd_ready,
  output logic [31:0] rd_data,
  output logic        fin,
  output logic        good
);

  localparam int NB_W = $clog2(4 * MAX_WORDS + HDR_BYTES) + 1;
  localparam logic [NB_W-1:0] NB_MAX = '1;

  logic            active;
  logic [NB_W-1:0] nb;
  logic [23:0]     wbuf;
  logic            rdv;
  logic [31:0]     rdd;
  logic [7:0]      ack0, ackhi, acklo;
  logic            fin_q;
  logic            wr_q;
  logic [7:0]      op_q;
  logic [15:0]     size_q;
  logic            take;
  logic            emit;

  assign rx_ready = active && !rdv;
  assign take     = rx_valid && rx_ready;
  assign emit     = !wr_q && (nb[1:0] == 2'd3) && (32'(nb) < 32'(size_q));
  assign rd_valid = rdv;
  assign rd_data  = rdd;
  assign fin      = fin_q;
  assign good     = wr_q ?
    ((32'(nb) == ACK_BYTES) && (ack0 == (op_q | ACK_FLAG)) && ({ackhi, acklo} == size_q)) :
    (32'(nb) == 32'(size_q));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      nb     <= '0;
      wbuf   <= '0;
      rdv    <= 1'b0;
      rdd    <= '0;
      ack0   <= 8'h00;
      ackhi  <= 8'h00;
      acklo  <= 8'h00;
      fin_q  <= 1'b0;
      wr_q   <= 1'b0;
      op_q   <= 8'h00;
      size_q <= '0;
    end else begin
      fin_q <= 1'b0;
      if (rdv && rd_ready) rdv <= 1'b0;
      if (start) begin
        active <= 1'b1;
        nb     <= '0;
        wr_q   <= is_wr;
        op_q   <= op;
        size_q <= size;
        ack0   <= 8'h00;
        ackhi  <= 8'h00;
        acklo  <= 8'h00;
      end else if (abort) begin
        active <= 1'b0;
      end else if (take) begin
        case (nb[1:0])
          2'd0: wbuf[7:0]   <= rx_data;
          2'd1: wbuf[15:8]  <= rx_data;
          2'd2: wbuf[23:16] <= rx_data;
          default: ;
        endcase
        if (emit) begin
          rdv <= 1'b1;
          rdd <= {rx_data, wbuf};
        end
        if (nb == NB_W'(0)) ack0  <= rx_data;
        if (nb == NB_W'(2)) ackhi <= rx_data;
        if (nb == NB_W'(3)) acklo <= rx_data;
        if (nb != NB_MAX) nb <= nb + NB_W'(1);
        if (rx_last) begin
          active <= 1'b0;
          fin_q  <= 1'b1;
        end
      end
    end
  end

  assert_rd_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));

  assert_fin_after_eop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fin |-> $past(rx_valid && rx_last));

endmodule

// File: rtl/reg_txn_engine.sv
module reg_txn_engine
  import reg_txn_pkg::*;
#(
  parameter int MAX_WORDS   = 16,
  parameter int CNT_W       = 16,
  parameter int TIMEOUT_CYC = 1000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic             cmd_write,
  input  logic [31:0]      cmd_addr,
  input  logic [CNT_W-1:0] cmd_count,
  input  logic             wd_valid,
  output logic             wd_ready,
  input  logic [31:0]      wd_data,
  output logic             tx_valid,
  input  logic             tx_ready,
  output logic [7:0]       tx_data,
  output logic             tx_last,
  input  logic             rx_valid,
  output logic             rx_ready,
  input  logic [7:0]       rx_data,
  input  logic             rx_last,
  output logic             rd_valid,
  input  logic             rd_ready,
  output logic [31:0]      rd_data,
  output logic             done,
  output logic [1:0]       done_status
);

  localparam int TMR_W = $clog2(TIMEOUT_CYC + 1);

  typedef enum logic [1:0] {S_IDLE, S_SEND, S_WAIT, S_DONE} state_e;

  state_e          state;
  txn_status_e     status_q;
  logic            wr_q;
  logic [7:0]      op_q;
  logic [15:0]     size_q;
  logic [TMR_W-1:0] tmr;

  logic        cmd_fire;
  logic        bad_cnt;
  logic [7:0]  op_n;
  logic [15:0] size_n;
  logic        tx_sent;
  logic        rx_fin;
  logic        rx_good;
  logic        eop_take;
  logic        expire;

  assign cmd_ready = (state == S_IDLE) && !rd_valid;
  assign cmd_fire  = cmd_valid && cmd_ready;
  assign bad_cnt   = (cmd_count == '0) || (32'(cmd_count) > MAX_WORDS);
  assign op_n      = op_code(cmd_write, cmd_count != CNT_W'(1));
  assign size_n    = 16'({cmd_count, 2'b00});
  assign eop_take  = rx_valid && rx_ready && rx_last;
  assign expire    = (state == S_WAIT) && (tmr == TMR_W'(TIMEOUT_CYC - 1)) && !rx_fin && !eop_take;
  assign done        = (state == S_DONE);
  assign done_status = status_q;

  reg_txn_tx #(.MAX_WORDS(MAX_WORDS)) tx_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (cmd_fire && !bad_cnt),
    .is_wr    (cmd_write),
    .op       (op_n),
    .addr     (cmd_addr),
    .size     (size_n),
    .tx_valid (tx_valid),
    .tx_ready (tx_ready),
    .tx_data  (tx_data),
    .tx_last  (tx_last),
    .wd_valid (wd_valid),
    .wd_ready (wd_ready),
    .wd_data  (wd_data),
    .sent     (tx_sent)
  );

  reg_txn_rx #(.MAX_WORDS(MAX_WORDS)) rx_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (tx_sent),
    .abort    (expire),
    .is_wr    (wr_q),
    .op       (op_q),
    .size     (size_q),
    .rx_valid (rx_valid),
    .rx_ready (rx_ready),
    .rx_data  (rx_data),
    .rx_last  (rx_last),
    .rd_valid (rd_valid),
    .rd_ready (rd_ready),
    .rd_data  (rd_data),
    .fin      (rx_fin),
    .good     (rx_good)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      status_q <= ST_OK;
      wr_q     <= 1'b0;
      op_q     <= 8'h00;
      size_q   <= '0;
      tmr      <= '0;
    end else begin
      case (state)
        S_IDLE: if (cmd_fire) begin
          wr_q   <= cmd_write;
          op_q   <= op_n;
          size_q <= size_n;
          if (bad_cnt) begin
            status_q <= ST_BADCNT;
            state    <= S_DONE;
          end else begin
            state <= S_SEND;
          end
        end
        S_SEND: if (tx_sent) begin
          tmr   <= '0;
          state <= S_WAIT;
        end
        S_WAIT: begin
          if (tmr != TMR_W'(TIMEOUT_CYC - 1)) tmr <= tmr + TMR_W'(1);
          if (rx_fin) begin
            status_q <= rx_good ? ST_OK : ST_BADRESP;
            state    <= S_DONE;
          end else if (expire) begin
            status_q <= ST_TIMEOUT;
            state    <= S_DONE;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assert_reject_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_fire && bad_cnt) |=> (done && done_status == ST_BADCNT));

  assert_quiet_tx_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (state != S_SEND) |-> !tx_valid);

  assert_done_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_timer_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_WAIT) |-> (32'(tmr) < TIMEOUT_CYC));

endmodule

// File: tb/reg_txn_engine_tb_top.sv
module reg_txn_engine_tb_top;

  localparam int MAXW = 16;
  localparam int CW   = 16;
  localparam int TMO  = 64;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic          rst_n;
  logic          cmd_valid, cmd_ready, cmd_write;
  logic [31:0]   cmd_addr;
  logic [CW-1:0] cmd_count;
  logic          wd_valid, wd_ready;
  logic [31:0]   wd_data;
  logic          tx_valid, tx_ready, tx_last;
  logic [7:0]    tx_data;
  logic          rx_valid, rx_ready, rx_last;
  logic [7:0]    rx_data;
  logic          rd_valid, rd_ready;
  logic [31:0]   rd_data;
  logic          done;
  logic [1:0]    done_status;

  reg_txn_engine #(.MAX_WORDS(MAXW), .CNT_W(CW), .TIMEOUT_CYC(TMO)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_write(cmd_write),
    .cmd_addr(cmd_addr), .cmd_count(cmd_count),
    .wd_valid(wd_valid), .wd_ready(wd_ready), .wd_data(wd_data),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data), .tx_last(tx_last),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data), .rx_last(rx_last),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
    .done(done), .done_status(done_status)
  );

  int n_tests = 0;
  int n_fail  = 0;

  logic [7:0]  txlog [0:127];
  logic        txlst [0:127];
  int          tx_n;
  logic [31:0] rdlog [0:31];
  int          rd_n;
  logic [31:0] wd_mem [0:31];
  int          wd_n, wd_idx;
  bit          wd_take;
  int          done_cnt;
  logic [1:0]  done_st;
  bit          bp;
  logic [7:0]  rxb [0:127];
  longint      cyc;

  assign wd_valid = (wd_idx < wd_n);
  assign wd_data  = (wd_idx < wd_n) ? wd_mem[wd_idx] : 32'h0;

  always @(negedge clk) begin
    cyc = cyc + 1;
    if (tx_valid && tx_ready) begin
      if (tx_n < 128) begin
        txlog[tx_n] = tx_data;
        txlst[tx_n] = tx_last;
      end
      tx_n++;
    end
    wd_take = wd_valid && wd_ready;
    if (rd_valid && rd_ready) begin
      if (rd_n < 32) rdlog[rd_n] = rd_data;
      rd_n++;
    end
    if (done) begin
      done_cnt++;
      done_st = done_status;
    end
  end

  always @(posedge clk) begin
    #1;
    if (wd_take) wd_idx++;
    if (bp) tx_ready = ~tx_ready;
    else    tx_ready = 1'b1;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] code_of(input bit wr, input int cnt);
    if (wr) return (cnt == 1) ? 8'h00 : 8'h04;
    else    return (cnt == 1) ? 8'h10 : 8'h14;
  endfunction

  task automatic clear_logs();
    tx_n = 0; rd_n = 0; done_cnt = 0; wd_idx = 0; wd_n = 0; done_st = 2'd0;
  endtask

  task automatic issue(input bit wr, input logic [31:0] addr, input int cnt);
    @(posedge clk); #1;
    cmd_valid = 1'b1; cmd_write = wr; cmd_addr = addr; cmd_count = CW'(cnt);
    do @(negedge clk); while (!cmd_ready);
    @(posedge clk); #1;
    cmd_valid = 1'b0;
  endtask

  task automatic wait_tx(input int n);
    for (int i = 0; i < 600 && tx_n < n; i++) @(negedge clk);
  endtask

  task automatic wait_done(input int lim);
    for (int i = 0; i < lim && done_cnt == 0; i++) @(negedge clk);
  endtask

  task automatic send_rx(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      rx_valid = 1'b1; rx_data = rxb[i]; rx_last = (i == n - 1);
      do @(negedge clk); while (!rx_ready);
    end
    @(posedge clk); #1;
    rx_valid = 1'b0; rx_last = 1'b0;
  endtask

  task automatic check_hdr(input string req, input bit wr, input int cnt, input logic [31:0] addr);
    logic [63:0] got, exp;
    got = {txlog[0], txlog[1], txlog[2], txlog[3], txlog[4], txlog[5], txlog[6], txlog[7]};
    exp = {code_of(wr, cnt), 8'h00, 16'(cnt * 4), addr};
    chk(got == exp, req, "header bytes (R1 R2 R3)", got, exp);
  endtask

  task automatic t_reset();
    chk(cmd_ready == 1'b1, "R12", "cmd_ready after reset", cmd_ready, 1);
    chk(tx_valid == 1'b0 && done == 1'b0, "R12", "tx_valid/done after reset",
        {tx_valid, done}, 0);
  endtask

  task automatic t_write(input int cnt, input bit use_bp, input logic [31:0] addr);
    bit lok;
    logic [31:0] w;
    clear_logs();
    for (int i = 0; i < cnt; i++) wd_mem[i] = 32'hA1B2C300 + 32'(i * 17);
    wd_n = cnt;
    bp = use_bp;
    issue(1'b1, addr, cnt);
    wait_tx(8 + 4 * cnt);
    bp = 1'b0;
    check_hdr("R1", 1'b1, cnt, addr);
    chk(tx_n == 8 + 4 * cnt, "R4", "request length", tx_n, 8 + 4 * cnt);
    for (int i = 0; i < cnt; i++) begin
      w = {txlog[8+4*i+3], txlog[8+4*i+2], txlog[8+4*i+1], txlog[8+4*i]};
      chk(w == wd_mem[i], use_bp ? "R11" : "R4", "payload word LE", w, wd_mem[i]);
    end
    lok = 1'b1;
    for (int i = 0; i < tx_n; i++) if (txlst[i] != (i == tx_n - 1)) lok = 1'b0;
    chk(lok, "R4", "tx_last only on final byte", lok, 1);
    chk(wd_idx == cnt, "R4", "write words consumed", wd_idx, cnt);
    rxb[0] = code_of(1'b1, cnt) | 8'h80; rxb[1] = 8'h00;
    rxb[2] = 8'((cnt * 4) >> 8); rxb[3] = 8'(cnt * 4);
    send_rx(4);
    wait_done(100);
    chk(done_cnt == 1, "R12", "one done pulse", done_cnt, 1);
    chk(done_st == 2'd0, "R8", "good write ack status", done_st, 0);
  endtask

  task automatic t_write_badack(input int cnt, input bit bad_size);
    clear_logs();
    for (int i = 0; i < cnt; i++) wd_mem[i] = 32'h5 + 32'(i);
    wd_n = cnt;
    issue(1'b1, 32'h0000_0040, cnt);
    wait_tx(8 + 4 * cnt);
    rxb[0] = code_of(1'b1, cnt) | (bad_size ? 8'h80 : 8'h00);
    rxb[1] = 8'h00; rxb[2] = 8'h00;
    rxb[3] = bad_size ? 8'(cnt * 4 + 4) : 8'(cnt * 4);
    send_rx(4);
    wait_done(100);
    chk(done_st == 2'd2, "R8", bad_size ? "ack size mismatch" : "ack code mismatch", done_st, 2);
  endtask

  task automatic t_read(input int cnt, input int nbytes, input logic [31:0] addr);
    bit ok;
    logic [31:0] w;
    clear_logs();
    issue(1'b0, addr, cnt);
    wait_tx(8);
    repeat (4) @(negedge clk);
    check_hdr("R2", 1'b0, cnt, addr);
    chk(tx_n == 8 && txlst[7] == 1'b1, "R5", "read request is header only", tx_n, 8);
    for (int i = 0; i < nbytes; i++) rxb[i] = 8'(8'h30 + i * 7);
    send_rx(nbytes);
    wait_done(100);
    if (nbytes == 4 * cnt) begin
      chk(done_st == 2'd0, "R7", "read status good", done_st, 0);
      chk(rd_n == cnt, "R6", "read word count", rd_n, cnt);
      ok = 1'b1;
      for (int i = 0; i < cnt; i++) begin
        w = {rxb[4*i+3], rxb[4*i+2], rxb[4*i+1], rxb[4*i]};
        if (i < rd_n) chk(rdlog[i] == w, "R6", "read word LE", rdlog[i], w);
      end
    end else begin
      chk(done_st == 2'd2, "R7", "read length mismatch", done_st, 2);
    end
  endtask

  task automatic t_reject(input int cnt);
    clear_logs();
    issue(1'b1, 32'h1234_5678, cnt);
    wait_done(20);
    repeat (3) @(negedge clk);
    chk(done_cnt == 1 && done_st == 2'd1, "R9", "bad count status", done_st, 1);
    chk(tx_n == 0, "R9", "no bytes for rejected count", tx_n, 0);
  endtask

  task automatic t_timeout();
    longint t0, dt;
    clear_logs();
    issue(1'b0, 32'hDEAD_0000, 1);
    wait_tx(8);
    t0 = cyc;
    wait_done(400);
    dt = cyc - t0;
    chk(done_cnt == 1 && done_st == 2'd3, "R10", "timeout status", done_st, 3);
    chk(dt >= TMO && dt <= TMO + 4, "R10", "timeout delay cycles", dt, TMO);
    chk(cmd_ready == 1'b1, "R12", "ready after timeout", cmd_ready, 1);
  endtask

  initial begin
    #(8 * 150000);
    n_tests++; n_fail++;
    $display("FAIL watchdog (R12): actual hung expected finished");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    cyc = 0; bp = 1'b0; tx_ready = 1'b1; rd_ready = 1'b1;
    cmd_valid = 1'b0; cmd_write = 1'b0; cmd_addr = '0; cmd_count = '0;
    rx_valid = 1'b0; rx_data = 8'h00; rx_last = 1'b0;
    clear_logs();
    rst_n = 1'b0;
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_write(1, 1'b0, 32'h8001_2340);
    t_write(3, 1'b1, 32'h0000_1000);
    t_read(1, 4, 32'h4000_00A8);
    t_read(2, 8, 32'h0102_0304);
    t_read(2, 7, 32'h0000_0010);
    t_write_badack(1, 1'b0);
    t_write_badack(2, 1'b1);
    t_reject(0);
    t_reject(MAXW + 1);
    t_write(MAXW, 1'b0, 32'hFFFF_FFFC);
    t_timeout();
    t_read(1, 4, 32'h0000_0004);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule